// File: doc/BRIEF.md
# Indirect Configuration Window Bridge

This block sits in front of a register region and carves two 32-bit ports out of the bottom of it. The first is a pointer port at window offset 0x0. The second is a data port at window offset 0x4. Software writes a pointer value to the pointer port. When the bits above the offset field match a fixed pattern, a window into configuration space opens. While the window is open, accesses that land on the data port go to the configuration-space port instead. The target is the latched offset plus the byte position inside the data port. All other host accesses reach the pass-through region unchanged, with a fixed base added to the address.

The host bus presents one access per cycle, using read and write strobes, an address, a size code and write data. All downstream strobes are registered. A read response comes back exactly one cycle after the downstream read strobe. Misuse of the window raises a sticky error output. There are two kinds of misuse: a pointer write that is not aligned to the pointer port, and a data access that only partly covers the data port while the window is open.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the window is closed, the latched offset is zero and `win_err` is low, so a data-port read is forwarded to the pass-through region.
- R2: A write starting at offset 0x0 whose bits 31..12 equal 0x00004 (value & ~0xFFF == 0x4000) opens the window and latches bits 11..0 as the target offset.
- R3: A write starting at offset 0x0 whose bits 31..12 differ from that pattern closes the window, and later data-port accesses go to the pass-through region.
- R4: A write that overlaps bytes 0x0..0x3 but does not start at 0x0 sets `win_err` and leaves the window state unchanged.
- R5: With the window open, a read fully inside bytes 0x4..0x7 issues `cfg_rd` one cycle after the request. The offset is latched offset + (address − 4), wrapping in 12 bits. `h_rvalid` follows one cycle later with the little-endian data masked to the access size.
- R6: With the window open, a write fully inside the data port issues `cfg_wr` with the host data and never issues `pt_wr`.
- R7: With the window open, an access that overlaps the data port but is not contained in it sets `win_err` and reaches neither port. A read of this kind still returns `h_rvalid` with data 0. With the window closed, the same access passes through and raises no error.
- R8: Every other access is forwarded to the pass-through port with `pt_addr = h_addr + 0x100` and the same size and data. This includes pointer-port writes. Pass-through read data is masked to the size.
- R9: `win_err` stays high once set, through later correct accesses, until reset.
- R10: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. Returned data keeps only the low bytes of that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe (wins over h_rd) |
| h_addr | input | AW (8) | Host byte address inside the region |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Host write data, little-endian lanes |
| h_rdata | output | 32 | Read response data |
| h_rvalid | output | 1 | Read response valid |
| cfg_rd | output | 1 | Configuration-space read strobe |
| cfg_wr | output | 1 | Configuration-space write strobe |
| cfg_off | output | OFF_W (12) | Configuration-space byte offset |
| cfg_size | output | 2 | Configuration access size code |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid while cfg_rd is high |
| pt_rd | output | 1 | Pass-through read strobe |
| pt_wr | output | 1 | Pass-through write strobe |
| pt_addr | output | PAW (16) | Pass-through byte address |
| pt_size | output | 2 | Pass-through access size code |
| pt_wdata | output | 32 | Pass-through write data |
| pt_rdata | input | 32 | Pass-through read data, valid while pt_rd is high |
| win_err | output | 1 | Sticky window misuse flag |

## Verification
A data-port read that was redirected can still have its response in flight on the edge where a following pointer write closes the window. Both the returned data and the state update therefore fall in the same cycle. The bench issues the read and then the closing pointer write on the next clock, with no gap. It judges the overlap by two results. The response must carry the configuration bytes chosen when the read was accepted. The forwarded pointer write must appear in the same cycle as that response. A further data read then has to reach the pass-through port.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    RT_PASS = 2'd0,
    RT_CFG  = 2'd1,
    RT_DROP = 2'd2
  } route_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PTR_OFF   = 0,
  parameter int DAT_OFF   = 4,
  parameter int REG_BYTES = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          ptr_hit,
  output logic          ptr_exact,
  output logic          dat_hit,
  output logic          dat_inside,
  output logic [AW-1:0] dat_rel
);
  localparam int EW = AW + 1;

  logic [EW-1:0] lo, hi;

  always_comb begin
    lo         = {1'b0, addr};
    hi         = lo + EW'(size_bytes(size));
    ptr_hit    = (lo < EW'(PTR_OFF + REG_BYTES)) && (hi > EW'(PTR_OFF));
    ptr_exact  = (lo == EW'(PTR_OFF));
    dat_hit    = (lo < EW'(DAT_OFF + REG_BYTES)) && (hi > EW'(DAT_OFF));
    dat_inside = (lo >= EW'(DAT_OFF)) && (hi <= EW'(DAT_OFF + REG_BYTES));
    dat_rel    = addr - AW'(DAT_OFF);
  end
endmodule

// File: rtl/cfgwin_state.sv
module cfgwin_state #(
  parameter int          OFF_W = 12,
  parameter logic [31:0] MATCH = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_wr,
  input  logic             ptr_exact,
  input  logic [31:0]      wdata,
  input  logic             bad_data,
  output logic             win_open,
  output logic [OFF_W-1:0] win_ofs,
  output logic             err
);
  localparam logic [31:0] MASK = 32'((64'd1 << OFF_W) - 64'd1);

  logic pattern_ok;
  assign pattern_ok = (wdata & ~MASK) == MATCH;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      win_ofs  <= '0;
      err      <= 1'b0;
    end else begin
      if (ptr_wr && ptr_exact) begin
        win_open <= pattern_ok;
        if (pattern_ok) win_ofs <= wdata[OFF_W-1:0];
      end
      if ((ptr_wr && !ptr_exact) || bad_data) err <= 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (!win_open && win_ofs == '0 && !err)); // R1
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst) !ptr_wr |=> $stable(win_ofs)); // R2
  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (rst) (ptr_wr && ptr_exact && !pattern_ok) |=> !win_open); // R3
  AST_SKEW_HOLDS: assert property (@(posedge clk) disable iff (rst) (ptr_wr && !ptr_exact) |=> ($stable(win_open) && err)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R9
endmodule

// File: rtl/cfgwin_resp.sv
module cfgwin_resp
  import cfgwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pend_cfg,
  input  logic        pend_pt,
  input  logic        pend_drop,
  input  logic [1:0]  size_q,
  input  logic [31:0] cfg_rdata,
  input  logic [31:0] pt_rdata,
  output logic [31:0] rdata,
  output logic        rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pend_cfg || pend_pt || pend_drop;
      if (pend_cfg)       rdata <= cfg_rdata & lane_mask(size_q);
      else if (pend_pt)   rdata <= pt_rdata & lane_mask(size_q);
      else if (pend_drop) rdata <= '0;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (pend_cfg || pend_pt || pend_drop) |=> rvalid); // R5
  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (rst) pend_drop |=> (rdata == 32'd0)); // R7
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgwin_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          PAW      = 16,
  parameter int          OFF_W    = 12,
  parameter logic [31:0] MATCH    = 32'h0000_4000,
  parameter int          BASE_OFF = 'h100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_rd,
  input  logic             h_wr,
  input  logic [AW-1:0]    h_addr,
  input  logic [1:0]       h_size,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  output logic             h_rvalid,
  output logic             cfg_rd,
  output logic             cfg_wr,
  output logic [OFF_W-1:0] cfg_off,
  output logic [1:0]       cfg_size,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata,
  output logic             pt_rd,
  output logic             pt_wr,
  output logic [PAW-1:0]   pt_addr,
  output logic [1:0]       pt_size,
  output logic [31:0]      pt_wdata,
  input  logic [31:0]      pt_rdata,
  output logic             win_err
);
  localparam int PTR_OFF   = 0;
  localparam int DAT_OFF   = 4;
  localparam int REG_BYTES = 4;

  logic             ptr_hit, ptr_exact, dat_hit, dat_inside;
  logic [AW-1:0]    dat_rel;
  logic             win_open;
  logic [OFF_W-1:0] win_ofs;
  logic             do_rd, do_wr, active;
  route_e           route;
  logic [1:0]       size_q;
  logic [31:0]      wdata_q;
  logic             drop_q;

  cfgwin_decode #(
    .AW(AW), .PTR_OFF(PTR_OFF), .DAT_OFF(DAT_OFF), .REG_BYTES(REG_BYTES)
  ) u_dec (
    .addr(h_addr), .size(h_size), .ptr_hit(ptr_hit), .ptr_exact(ptr_exact),
    .dat_hit(dat_hit), .dat_inside(dat_inside), .dat_rel(dat_rel)
  );

  assign do_wr  = h_wr;
  assign do_rd  = h_rd && !h_wr;
  assign active = do_wr || do_rd;

  always_comb begin
    route = RT_PASS;
    if (win_open && dat_hit) route = dat_inside ? RT_CFG : RT_DROP;
  end

  cfgwin_state #(.OFF_W(OFF_W), .MATCH(MATCH)) u_state (
    .clk(clk), .rst(rst),
    .ptr_wr(do_wr && ptr_hit), .ptr_exact(ptr_exact), .wdata(h_wdata),
    .bad_data(active && route == RT_DROP),
    .win_open(win_open), .win_ofs(win_ofs), .err(win_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rd  <= 1'b0;
      cfg_wr  <= 1'b0;
      cfg_off <= '0;
      pt_rd   <= 1'b0;
      pt_wr   <= 1'b0;
      pt_addr <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      cfg_rd <= 1'b0;
      cfg_wr <= 1'b0;
      pt_rd  <= 1'b0;
      pt_wr  <= 1'b0;
      drop_q <= 1'b0;
      if (active) begin
        size_q  <= h_size;
        wdata_q <= h_wdata;
        case (route)
          RT_CFG: begin
            cfg_rd  <= do_rd;
            cfg_wr  <= do_wr;
            cfg_off <= win_ofs + OFF_W'(dat_rel);
          end
          RT_DROP: drop_q <= do_rd;
          default: begin
            pt_rd   <= do_rd;
            pt_wr   <= do_wr;
            pt_addr <= PAW'(h_addr) + PAW'(BASE_OFF);
          end
        endcase
      end
    end
  end

  assign cfg_size  = size_q;
  assign pt_size   = size_q;
  assign cfg_wdata = wdata_q;
  assign pt_wdata  = wdata_q;

  cfgwin_resp u_resp (
    .clk(clk), .rst(rst),
    .pend_cfg(cfg_rd), .pend_pt(pt_rd), .pend_drop(drop_q),
    .size_q(size_q), .cfg_rdata(cfg_rdata), .pt_rdata(pt_rdata),
    .rdata(h_rdata), .rvalid(h_rvalid)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0({cfg_rd, cfg_wr, pt_rd, pt_wr, drop_q})); // R6
  AST_CFG_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst) (cfg_rd || cfg_wr) |-> win_open); // R5
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst) drop_q |-> win_err); // R7
endmodule

// File: tb/sim_cfg_window_bridge.sv
module sim_cfg_window_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_rvalid;
  logic        cfg_rd, cfg_wr;
  logic [11:0] cfg_off;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        pt_rd, pt_wr;
  logic [15:0] pt_addr;
  logic [1:0]  pt_size;
  logic [31:0] pt_wdata, pt_rdata;
  logic        win_err;

  always #10 clk = ~clk;

  cfg_window_bridge u0 (
    .clk(clk), .rst(rst), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pt_rd(pt_rd), .pt_wr(pt_wr), .pt_addr(pt_addr), .pt_size(pt_size),
    .pt_wdata(pt_wdata), .pt_rdata(pt_rdata), .win_err(win_err)
  );

  logic [7:0] cmem [4096];

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] cexp(input logic [11:0] off, input logic [1:0] s);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = cmem[12'(off + 12'(k))];
    return v & msk(s);
  endfunction
  function automatic logic [31:0] ptexp(input logic [15:0] a, input logic [1:0] s);
    return {a, ~a} & msk(s);
  endfunction

  assign cfg_rdata = {cmem[12'(cfg_off + 12'd3)], cmem[12'(cfg_off + 12'd2)],
                      cmem[12'(cfg_off + 12'd1)], cmem[cfg_off]};
  assign pt_rdata  = {pt_addr, ~pt_addr};

  always @(posedge clk)
    if (cfg_wr)
      for (int k = 0; k < nbytes(cfg_size); k++) cmem[12'(cfg_off + 12'(k))] <= cfg_wdata[8*k +: 8];

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic        s_cfg_rd, s_cfg_wr, s_pt_rd, s_pt_wr, s_rvalid;
  logic [11:0] s_cfg_off;
  logic [15:0] s_pt_addr;
  logic [31:0] s_cfg_wdata, s_pt_wdata, s_rdata;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic snap_ports();
    s_cfg_rd = cfg_rd; s_cfg_wr = cfg_wr; s_pt_rd = pt_rd; s_pt_wr = pt_wr;
    s_cfg_off = cfg_off; s_pt_addr = pt_addr;
    s_cfg_wdata = cfg_wdata; s_pt_wdata = pt_wdata;
  endtask

  task automatic acc(input bit wr, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    h_wr = wr; h_rd = !wr; h_addr = a; h_size = sz; h_wdata = d;
    @(negedge clk);
    snap_ports();
    h_wr = 1'b0; h_rd = 1'b0;
    @(negedge clk);
    s_rvalid = h_rvalid; s_rdata = h_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "err after reset", 32'(win_err), 32'd0);
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R1", "closed data read to pass-through", {s_pt_rd, s_cfg_rd}, 2'b10);
    chk("R8", "pass-through address", 32'(s_pt_addr), 32'h104);
    chk("R8", "pass-through read data", s_rdata, ptexp(16'h104, 2'd2));
  endtask

  task automatic t_open();
    acc(1'b1, 8'h00, 2'd2, 32'h0000_4010);
    chk("R8", "pointer write forwarded", {s_pt_wr, 16'(s_pt_addr)}, {1'b1, 16'h100});
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R2", "window open read strobes", {s_cfg_rd, s_pt_rd}, 2'b10);
    chk("R2", "latched offset", 32'(s_cfg_off), 32'h010);
    chk("R5", "word read data", s_rdata, cexp(12'h010, 2'd2));
    chk("R5", "rvalid", 32'(s_rvalid), 32'd1);
  endtask

  task automatic t_bytes();
    acc(1'b0, 8'h05, 2'd0, 0);
    chk("R5", "byte offset", 32'(s_cfg_off), 32'h011);
    chk("R10", "byte data masked", s_rdata, cexp(12'h011, 2'd0));
    acc(1'b0, 8'h06, 2'd1, 0);
    chk("R5", "half offset", 32'(s_cfg_off), 32'h012);
    chk("R10", "half data masked", s_rdata, cexp(12'h012, 2'd1));
  endtask

  task automatic t_cfg_write();
    acc(1'b1, 8'h04, 2'd2, 32'hA5C3_1E77);
    chk("R6", "cfg write, no pass-through", {s_cfg_wr, s_pt_wr}, 2'b10);
    chk("R6", "cfg write data", s_cfg_wdata, 32'hA5C3_1E77);
    acc(1'b1, 8'h07, 2'd0, 32'h0000_005A);
    chk("R6", "byte write offset", 32'(s_cfg_off), 32'h013);
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R6", "read back", s_rdata, 32'h5AC3_1E77);
  endtask

  task automatic t_wrap();
    acc(1'b1, 8'h00, 2'd2, 32'h0000_4FFF);
    acc(1'b0, 8'h06, 2'd1, 0);
    chk("R5", "offset wraps", 32'(s_cfg_off), 32'h001);
    chk("R5", "wrapped data", s_rdata, cexp(12'h001, 2'd1));
  endtask

  task automatic t_overlap();
    logic [31:0] exp_d;
    acc(1'b1, 8'h00, 2'd2, 32'h0000_4020);
    exp_d = cexp(12'h020, 2'd2);
    h_rd = 1'b1; h_addr = 8'h04; h_size = 2'd2;
    @(negedge clk);
    snap_ports();
    h_rd = 1'b0; h_wr = 1'b1; h_addr = 8'h00; h_wdata = 32'h0000_9000;
    @(negedge clk);
    chk("R5", "read issued before close", 32'(s_cfg_rd), 32'd1);
    chk("R5", "response during close", {h_rvalid, h_rdata}, {1'b1, exp_d});
    chk("R8", "close write forwarded same cycle", 32'(pt_wr), 32'd1);
    h_wr = 1'b0;
    @(negedge clk);
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R3", "closed window passes through", {s_pt_rd, s_cfg_rd}, 2'b10);
  endtask

  task automatic t_partial();
    acc(1'b0, 8'h06, 2'd2, 0);
    chk("R7", "closed partial passes", {s_pt_rd, win_err}, 2'b10);
    acc(1'b1, 8'h00, 2'd2, 32'h0000_4000);
    acc(1'b0, 8'h06, 2'd2, 0);
    chk("R7", "open partial reaches no port", {s_cfg_rd, s_pt_rd}, 2'b00);
    chk("R7", "partial read response", {s_rvalid, s_rdata}, {1'b1, 32'd0});
    chk("R7", "partial raises err", 32'(win_err), 32'd1);
  endtask

  task automatic t_sticky();
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R9", "good access after error", s_rdata, cexp(12'h000, 2'd2));
    repeat (10) @(negedge clk);
    chk("R9", "err held", 32'(win_err), 32'd1);
    do_reset();
    chk("R9", "err cleared by reset", 32'(win_err), 32'd0);
  endtask

  task automatic t_skew();
    acc(1'b1, 8'h02, 2'd2, 32'h0000_4000);
    chk("R4", "skewed pointer write err", 32'(win_err), 32'd1);
    chk("R8", "skewed write forwarded", {s_pt_wr, 16'(s_pt_addr)}, {1'b1, 16'h102});
    acc(1'b0, 8'h04, 2'd2, 0);
    chk("R4", "window stays closed", {s_pt_rd, s_cfg_rd}, 2'b10);
  endtask

  task automatic t_other();
    acc(1'b1, 8'h40, 2'd2, 32'h1234_5678);
    chk("R8", "other write", {s_pt_wr, 16'(s_pt_addr)}, {1'b1, 16'h140});
    chk("R8", "other write data", s_pt_wdata, 32'h1234_5678);
    acc(1'b0, 8'h41, 2'd0, 0);
    chk("R10", "other byte read", s_rdata, ptexp(16'h141, 2'd0));
    acc(1'b1, 8'h04, 2'd2, 32'hDEAD_0001);
    chk("R8", "closed data write passes", {s_pt_wr, s_cfg_wr}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) cmem[i] = 8'(i * 13 + 5);
    @(negedge clk);
    t_reset();
    t_open();
    t_bytes();
    t_cfg_write();
    t_wrap();
    t_overlap();
    t_partial();
    t_sticky();
    t_skew();
    t_other();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule